// File: doc/BRIEF.md
# Interrupt Pending/Active State Tracker

This block keeps the service state of a small set of peripheral interrupt lines. Each line is in one of four states: idle, pending, in service (active), or in service with a fresh request waiting (active and pending). The two flags are registered on the rising clock edge. Each line is configured as either level-triggered or edge-triggered. The trigger type decides how hardware requests, software clears and handler exits change the state.

The processor side reports two events. One is an entry strobe with a line number, given when a handler starts. The other is an exit strobe with a line number, given when a handler finishes. Software can mark lines pending or clear their pending flag through two masked strobes. The block offers a take request whenever no line is in service and at least one enabled line is pending. With that request it gives the number of the lowest such line. The enable bits gate only this offer. A disabled line still collects pending state.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset, every pending and active flag is 0, take_req_o is 0 and take_id_o is 0.
- R2: A level-triggered line (mode bit 0) whose request is high for at least one sampled cycle, while the line is not active, is pending in the cycle after that edge.
- R3: An edge-triggered line (mode bit 1) becomes pending after a low-to-high change of its request is sampled. A request held high raises no second pending after that pending is cleared.
- R4: A software set strobe makes every line selected in its mask pending, in either mode, whether or not the line's enable bit is 1.
- R5: An entry strobe for line n clears line n's pending flag and sets its active flag. A level request still high at entry does not make the line pending again while it is active.
- R6: On an exit strobe for a level-triggered line, the line becomes pending if its request is high in that cycle, and idle otherwise.
- R7: A new rising edge on an edge-triggered line while it is active sets pending next to active. On exit, the line is pending if such an edge arrived, and idle if none did.
- R8: A software clear on a level-triggered line leaves it pending while its request is high. When the request is low, the clear makes the line idle.
- R9: A software clear on an edge-triggered line turns pending into idle, and turns active-and-pending into active only.
- R10: When set and clear select the same line in one cycle, the clear wins. A hardware pending event in that same cycle wins over both.
- R11: take_req_o is 1 only when no line is active and some line is both enabled and pending. take_id_o is then the lowest such line number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_LINES | Synchronous request per line |
| irq_pulse_mode | input | NUM_LINES | Per line: 1 edge-triggered, 0 level-triggered |
| irq_en | input | NUM_LINES | Per-line enable for the take request |
| sw_set_stb | input | 1 | Software set-pending strobe |
| sw_set_mask | input | NUM_LINES | Lines selected by the set strobe |
| sw_clr_stb | input | 1 | Software clear-pending strobe |
| sw_clr_mask | input | NUM_LINES | Lines selected by the clear strobe |
| enter_stb | input | 1 | Handler entry strobe |
| enter_id | input | LINE_W | Line number being entered |
| ret_stb | input | 1 | Handler exit strobe |
| ret_id | input | LINE_W | Line number being exited |
| pend_o | output | NUM_LINES | Pending flags |
| act_o | output | NUM_LINES | Active flags |
| take_req_o | output | 1 | Offer of a line to service |
| take_id_o | output | LINE_W | Number of the offered line |

## Verification
The assertions assume that the processor side behaves sensibly. An entry strobe arrives only while no line is active. An exit strobe names the line that is currently active. Entry and exit are never given in the same cycle. The bench follows these rules. It enters a line only after checking that every active flag is clear, and it exits only the line it entered. It runs a full sweep of all pending and enable patterns for the take logic, and it runs the per-line state sequences on every line in both trigger modes.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_PULSE = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic pend;
        logic act;
        logic req_seen;
    } line_state_t;

    localparam line_state_t LINE_IDLE = '{pend: 1'b0, act: 1'b0, req_seen: 1'b0};

endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic pulse_mode,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic enter,
    input  logic ret,
    output logic pend,
    output logic act
);

    line_state_t line_d, line_q;
    trig_mode_e  mode;
    logic        rise;
    logic        hw_evt;

    assign mode = trig_mode_e'(pulse_mode);

    always_comb begin
        line_d          = line_q;
        line_d.req_seen = req;
        rise            = req & ~line_q.req_seen;

        if (enter) begin
            line_d.pend = 1'b0;
            line_d.act  = 1'b1;
        end
        if (ret) begin
            line_d.act = 1'b0;
            if (mode == TRIG_LEVEL) begin
                line_d.pend = 1'b0;
            end
        end

        if (sw_clr) begin
            if (mode == TRIG_PULSE || !req) begin
                line_d.pend = 1'b0;
            end
        end else if (sw_set) begin
            line_d.pend = 1'b1;
        end

        if (mode == TRIG_PULSE) begin
            hw_evt = rise;
        end else begin
            hw_evt = req & ~line_d.act;
        end
        if (hw_evt) begin
            line_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= LINE_IDLE;
        end else begin
            line_q <= line_d;
        end
    end

    assign pend = line_q.pend;
    assign act  = line_q.act;

    p_level_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && req && !line_q.act && !enter) |=> line_q.pend);

    p_edge_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && req && !line_q.req_seen) |=> line_q.pend);

    p_enter_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> line_q.act);

    p_level_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !pulse_mode && !sw_set) |=> (line_q.pend == $past(req)) && !line_q.act);

    p_edge_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && sw_clr && !(req && !line_q.req_seen) && !enter && !ret)
        |=> !line_q.pend && (line_q.act == $past(line_q.act)));

    p_clear_beats_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && sw_set && sw_clr && !req && !enter && !ret) |=> !line_q.pend);

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int NUM_LINES = 4,
    parameter int LINE_W    = 2
) (
    input  logic [NUM_LINES-1:0] cand,
    input  logic                 busy,
    output logic                 take,
    output logic [LINE_W-1:0]    id
);

    logic found;

    always_comb begin
        found = 1'b0;
        id    = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                id    = LINE_W'(i);
            end
        end
        take = found & ~busy;
    end

endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
    parameter int NUM_LINES = 4,
    parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic [NUM_LINES-1:0] irq_pulse_mode,
    input  logic [NUM_LINES-1:0] irq_en,
    input  logic                 sw_set_stb,
    input  logic [NUM_LINES-1:0] sw_set_mask,
    input  logic                 sw_clr_stb,
    input  logic [NUM_LINES-1:0] sw_clr_mask,
    input  logic                 enter_stb,
    input  logic [LINE_W-1:0]    enter_id,
    input  logic                 ret_stb,
    input  logic [LINE_W-1:0]    ret_id,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] act_o,
    output logic                 take_req_o,
    output logic [LINE_W-1:0]    take_id_o
);

    logic [NUM_LINES-1:0] enter_hit;
    logic [NUM_LINES-1:0] ret_hit;
    logic [NUM_LINES-1:0] cand;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign enter_hit[g] = enter_stb && (enter_id == LINE_W'(g));
        assign ret_hit[g]   = ret_stb && (ret_id == LINE_W'(g));

        irq_line_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (irq_req[g]),
            .pulse_mode (irq_pulse_mode[g]),
            .sw_set     (sw_set_stb & sw_set_mask[g]),
            .sw_clr     (sw_clr_stb & sw_clr_mask[g]),
            .enter      (enter_hit[g]),
            .ret        (ret_hit[g]),
            .pend       (pend_o[g]),
            .act        (act_o[g])
        );
    end

    assign cand = pend_o & irq_en;

    irq_lowest_pick #(
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W)
    ) u_pick (
        .cand (cand),
        .busy (|act_o),
        .take (take_req_o),
        .id   (take_id_o)
    );

    p_take_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take_req_o |-> (act_o == '0));

    p_take_lowest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take_req_o |-> (cand[take_id_o]
            && ((cand & ((NUM_LINES'(1) << take_id_o) - NUM_LINES'(1))) == '0)));

    p_take_present_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o == '0 && cand != '0) |-> take_req_o);

    p_single_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_o));

endmodule

// File: tb/irq_state_tracker_tb.sv
module irq_state_tracker_tb;

    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0, irq_pulse_mode = '0, irq_en = '0;
    logic         sw_set_stb = 1'b0, sw_clr_stb = 1'b0;
    logic [N-1:0] sw_set_mask = '0, sw_clr_mask = '0;
    logic         enter_stb = 1'b0, ret_stb = 1'b0;
    logic [W-1:0] enter_id = '0, ret_id = '0;
    logic [N-1:0] pend_o, act_o;
    logic         take_req_o;
    logic [W-1:0] take_id_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_state_tracker #(.NUM_LINES(N)) u_dut (
        .clk, .rst_n, .irq_req, .irq_pulse_mode, .irq_en,
        .sw_set_stb, .sw_set_mask, .sw_clr_stb, .sw_clr_mask,
        .enter_stb, .enter_id, .ret_stb, .ret_id,
        .pend_o, .act_o, .take_req_o, .take_id_o
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        sw_set_stb = 1'b0;
        sw_clr_stb = 1'b0;
        enter_stb  = 1'b0;
        ret_stb    = 1'b0;
    endtask

    task automatic do_reset();
        irq_req = '0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pend", int'(pend_o), 0);
        chk("R1 act", int'(act_o), 0);
        chk("R1 take", int'(take_req_o), 0);
        chk("R1 id", int'(take_id_o), 0);

        for (int i = 0; i < N; i++) begin
            // level-triggered sequence on line i
            do_reset();
            irq_pulse_mode = '0;
            irq_en = '1;
            irq_req[i] = 1'b1;
            step();
            irq_req[i] = 1'b0;
            chk("R2 one-cycle level captured", int'(pend_o), 1 << i);
            chk("R2 not active", int'(act_o), 0);
            sw_clr_stb = 1'b1; sw_clr_mask = N'(1) << i;
            step();
            chk("R8 clear with request low", int'(pend_o), 0);
            irq_req[i] = 1'b1;
            step();
            sw_clr_stb = 1'b1; sw_clr_mask = N'(1) << i;
            step();
            chk("R8 clear ignored while request high", int'(pend_o), 1 << i);
            chk("R11 take id", int'(take_id_o), i);
            chk("R11 take req", int'(take_req_o), 1);
            enter_stb = 1'b1; enter_id = W'(i);
            step();
            chk("R5 enter active", int'(act_o), 1 << i);
            chk("R5 enter clears pending, no level re-pend", int'(pend_o), 0);
            chk("R11 no take while active", int'(take_req_o), 0);
            ret_stb = 1'b1; ret_id = W'(i);
            step();
            chk("R6 exit with request high pends", int'(pend_o), 1 << i);
            chk("R6 exit clears active", int'(act_o), 0);
            enter_stb = 1'b1; enter_id = W'(i);
            step();
            irq_req[i] = 1'b0;
            ret_stb = 1'b1; ret_id = W'(i);
            step();
            chk("R6 exit with request low idles", int'(pend_o) + 16 * int'(act_o), 0);

            // edge-triggered sequence on line i
            do_reset();
            irq_pulse_mode = '1;
            irq_req[i] = 1'b1;
            step();
            chk("R3 rising edge pends", int'(pend_o), 1 << i);
            sw_clr_stb = 1'b1; sw_clr_mask = N'(1) << i;
            step();
            chk("R9 clear pending to idle", int'(pend_o), 0);
            step();
            chk("R3 held request does not re-pend", int'(pend_o), 0);
            irq_req[i] = 1'b0;
            step();
            irq_req[i] = 1'b1;
            step();
            enter_stb = 1'b1; enter_id = W'(i);
            step();
            chk("R5 edge line entered", int'(act_o) * 16 + int'(pend_o), 16 << i);
            irq_req[i] = 1'b0;
            step();
            irq_req[i] = 1'b1;
            step();
            chk("R7 edge while active", int'(act_o) * 16 + int'(pend_o), (16 << i) + (1 << i));
            sw_clr_stb = 1'b1; sw_clr_mask = N'(1) << i;
            step();
            chk("R9 clear keeps active only", int'(act_o) * 16 + int'(pend_o), 16 << i);
            irq_req[i] = 1'b0;
            step();
            irq_req[i] = 1'b1;
            step();
            ret_stb = 1'b1; ret_id = W'(i);
            step();
            chk("R7 exit after edge pends", int'(act_o) * 16 + int'(pend_o), 1 << i);
            enter_stb = 1'b1; enter_id = W'(i);
            step();
            ret_stb = 1'b1; ret_id = W'(i);
            step();
            chk("R7 exit without edge idles", int'(act_o) * 16 + int'(pend_o), 0);

            // software set in both modes with enable clear
            for (int m = 0; m < 2; m++) begin
                do_reset();
                irq_pulse_mode = m[0] ? '1 : '0;
                irq_en = '0;
                sw_set_stb = 1'b1; sw_set_mask = N'(1) << i;
                step();
                chk("R4 set pends while disabled", int'(pend_o), 1 << i);
                chk("R4 disabled line not offered", int'(take_req_o), 0);
            end

            // set and clear together, then with a hardware edge
            do_reset();
            irq_pulse_mode = '1;
            sw_set_stb = 1'b1; sw_set_mask = N'(1) << i;
            sw_clr_stb = 1'b1; sw_clr_mask = N'(1) << i;
            step();
            chk("R10 clear beats set", int'(pend_o), 0);
            sw_set_stb = 1'b1; sw_set_mask = N'(1) << i;
            sw_clr_stb = 1'b1; sw_clr_mask = N'(1) << i;
            irq_req[i] = 1'b1;
            step();
            chk("R10 hardware edge beats clear", int'(pend_o), 1 << i);
        end

        // R11 sweep over every pending and enable pattern
        do_reset();
        irq_pulse_mode = '1;
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 16; e++) begin
                sw_clr_stb = 1'b1; sw_clr_mask = '1;
                step();
                sw_set_stb = 1'b1; sw_set_mask = N'(p);
                irq_en = N'(e);
                step();
                begin
                    int c;
                    int lo;
                    c = p & e;
                    lo = 0;
                    for (int b = N - 1; b >= 0; b--) if (c[b]) lo = b;
                    chk("R11 sweep take", int'(take_req_o), (c != 0) ? 1 : 0);
                    if (c != 0) chk("R11 sweep id", int'(take_id_o), lo);
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule